// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit memory-mapped host reach a slow 8-bit register space that sits behind it. The host never touches the inner registers directly. It programs a control word that holds the inner register address, the transfer direction and the byte-lane enables. It then moves the byte through a data word. An inner read starts as soon as the control word is written with the read direction. An inner write starts when the lower data word is written after a control word with the write direction and lane 0 enabled.

While a transfer runs, a busy bit in the control word reads high. Software polls this bit before and after each access. The inner bus is a simple master port: one request cycle, with address, direction and write byte held steady. The read byte is sampled a fixed, parameterised number of cycles after the request. The bridge also gathers two interrupt causes into a flag/enable pair: completion of an inner transfer and a rising edge on the inner subsystem's interrupt line. The host interrupt output is driven from that pair.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the control, lower data, upper data, interrupt enable and interrupt flag words all read 0, host_irq is low, and offset 0x00 reads the constant ID_VALUE.
- R2: A host write to offset 0x04 while idle stores bit 24 (direction, 1 = inner read), bits 23:16 (byte enables, bit 16 = lane 0) and bits 7:0 (inner address). Reading 0x04 returns these fields with bit 31 = busy and all other bits 0. A write with bit 24 = 0 starts no transfer.
- R3: Writing 0x04 with bit 24 = 1 while idle issues exactly one inner request cycle with inb_we = 0 and inb_addr = the written bits 7:0. Busy then reads 1 for exactly LAT cycles. The sampled byte lands in lower data bits 7:0, and lower data bits 31:8 become 0.
- R4: Writing offset 0x08 while idle, with stored direction 0 and stored bit 16 = 1, stores the word and issues one inner write of its bits 7:0 to the stored address. Busy is held for LAT cycles. With stored bit 16 = 0 the word is only stored and no inner request occurs.
- R5: While busy reads 1, host writes to 0x04, 0x08 and 0x0C are ignored.
- R6: Offset 0x0C is a plain 32-bit read/write word that never starts a transfer.
- R7: Interrupt flag bit 0 (offset 0x14) sets when an inner transfer completes. Flag bit 1 sets on a rising edge of sub_irq only; a held-high level does not set it again.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it. A set event in the same cycle as a clear wins.
- R9: host_irq is high one cycle after any flag bit is 1 while the matching bit of the enable word (offset 0x10, bits 1:0) is 1, and low otherwise.
- R10: Host read data appears on hst_rdata in the cycle after the read request. Unmapped offsets read 0 and ignore writes.
- R11: inb_addr, inb_we and inb_wdata stay stable for the whole of a transfer after its request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_en | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | HADDR_W | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| inb_req | output | 1 | Inner request, one cycle per transfer |
| inb_we | output | 1 | Inner transfer is a write |
| inb_addr | output | 8 | Inner register address |
| inb_wdata | output | 8 | Inner write byte |
| inb_rdata | input | 8 | Inner read byte, sampled LAT cycles after the request |
| sub_irq | input | 1 | Interrupt level from the inner subsystem |
| host_irq | output | 1 | Combined host interrupt, registered |

## Verification
A stuck or miscounting transfer FSM shows within one transfer as a wrong number of busy polls. It can also show as a missing or doubled inner request, or as a byte taken from the wrong sample point, which then reads back wrong from the lower data word. Corrupted control or data storage appears on the next read of that offset. This includes writes that should have been dropped while busy. Interrupt flag errors appear on the flag read and on host_irq one cycle later, in particular the set-versus-clear collision and the held-level case on sub_irq.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // host map offsets
  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_LDAT = 8'h08;
  localparam logic [7:0] OFS_UDAT = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h10;
  localparam logic [7:0] OFS_IFLG = 8'h14;

  localparam int HOST_DW  = 32;
  localparam int INNER_AW = 8;
  localparam int INNER_DW = 8;
  localparam int BEN_W    = 8;

  // control word bit positions
  localparam int CB_BUSY = 31;
  localparam int CB_DIR  = 24;
  localparam int CB_BEN  = 16;

  // interrupt causes
  localparam int NUM_IRQ  = 2;
  localparam int IRQ_XFER = 0;
  localparam int IRQ_SUB  = 1;

  typedef struct packed {
    logic                dir;
    logic [BEN_W-1:0]    ben;
    logic [INNER_AW-1:0] addr;
  } ctrl_t;
endpackage

// File: rtl/brg_host_regs.sv
module brg_host_regs
  import brg_pkg::*;
#(
  parameter int          HADDR_W  = 8,
  parameter logic [31:0] ID_VALUE = 32'h0B1D_0100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hst_en,
  input  logic                 hst_we,
  input  logic [HADDR_W-1:0]   hst_addr,
  input  logic [HOST_DW-1:0]   hst_wdata,
  output logic [HOST_DW-1:0]   hst_rdata,
  input  logic                 busy_i,
  input  logic                 cap_i,
  input  logic [INNER_DW-1:0]  cap_data_i,
  input  logic [NUM_IRQ-1:0]   flag_i,
  output logic                 start_o,
  output logic                 start_we_o,
  output logic [INNER_AW-1:0]  start_addr_o,
  output logic [INNER_DW-1:0]  start_wdata_o,
  output logic [NUM_IRQ-1:0]   ien_o,
  output logic [NUM_IRQ-1:0]   fclr_o
);
  ctrl_t                ctrl_q;
  logic [HOST_DW-1:0]   ldat_q, udat_q, rd_mux;
  logic [NUM_IRQ-1:0]   ien_q;
  logic                 wr, rd;
  logic                 sel_id, sel_ctrl, sel_ldat, sel_udat, sel_ien, sel_iflg;
  logic                 wr_ctrl, wr_ldat, wr_udat, start_rd, start_wr;

  assign wr       = hst_en & hst_we;
  assign rd       = hst_en & ~hst_we;
  assign sel_id   = (hst_addr == HADDR_W'(OFS_ID));
  assign sel_ctrl = (hst_addr == HADDR_W'(OFS_CTRL));
  assign sel_ldat = (hst_addr == HADDR_W'(OFS_LDAT));
  assign sel_udat = (hst_addr == HADDR_W'(OFS_UDAT));
  assign sel_ien  = (hst_addr == HADDR_W'(OFS_IEN));
  assign sel_iflg = (hst_addr == HADDR_W'(OFS_IFLG));

  // writes to the transfer words are dropped while busy
  assign wr_ctrl  = wr & sel_ctrl & ~busy_i;
  assign wr_ldat  = wr & sel_ldat & ~busy_i;
  assign wr_udat  = wr & sel_udat & ~busy_i;

  assign start_rd = wr_ctrl & hst_wdata[CB_DIR];
  assign start_wr = wr_ldat & ~ctrl_q.dir & ctrl_q.ben[0];

  assign start_o       = start_rd | start_wr;
  assign start_we_o    = start_wr;
  assign start_addr_o  = start_rd ? hst_wdata[INNER_AW-1:0] : ctrl_q.addr;
  assign start_wdata_o = hst_wdata[INNER_DW-1:0];
  assign ien_o         = ien_q;
  assign fclr_o        = (wr & sel_iflg) ? hst_wdata[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ldat_q <= '0;
      udat_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.dir  <= hst_wdata[CB_DIR];
        ctrl_q.ben  <= hst_wdata[CB_BEN +: BEN_W];
        ctrl_q.addr <= hst_wdata[INNER_AW-1:0];
      end
      if (cap_i)        ldat_q <= {{(HOST_DW-INNER_DW){1'b0}}, cap_data_i};
      else if (wr_ldat) ldat_q <= hst_wdata;
      if (wr_udat)      udat_q <= hst_wdata;
      if (wr & sel_ien) ien_q  <= hst_wdata[NUM_IRQ-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_id)   rd_mux = ID_VALUE;
    if (sel_ctrl) rd_mux = {busy_i, {(CB_BUSY-CB_DIR-1){1'b0}}, ctrl_q.dir, ctrl_q.ben,
                            {(CB_BEN-INNER_AW){1'b0}}, ctrl_q.addr};
    if (sel_ldat) rd_mux = ldat_q;
    if (sel_udat) rd_mux = udat_q;
    if (sel_ien)  rd_mux = {{(HOST_DW-NUM_IRQ){1'b0}}, ien_q};
    if (sel_iflg) rd_mux = {{(HOST_DW-NUM_IRQ){1'b0}}, flag_i};
  end

  always_ff @(posedge clk) begin
    if (rst)     hst_rdata <= '0;
    else if (rd) hst_rdata <= rd_mux;
  end

  AST_CTRL_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (ctrl_q == $past(ctrl_q)));                         // R5
  AST_LDAT_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !cap_i) |=> $stable(ldat_q));                        // R5
  AST_UDAT_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(udat_q));                                    // R5
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !start_o);                                           // R5
endmodule

// File: rtl/brg_xfer_fsm.sv
module brg_xfer_fsm
  import brg_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                we_i,
  input  logic [INNER_AW-1:0] addr_i,
  input  logic [INNER_DW-1:0] wdata_i,
  output logic                busy_o,
  output logic                cap_o,
  output logic                done_o,
  output logic                inb_req_o,
  output logic                inb_we_o,
  output logic [INNER_AW-1:0] inb_addr_o,
  output logic [INNER_DW-1:0] inb_wdata_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  typedef enum logic {S_IDLE, S_WAIT} state_t;
  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last   = (state == S_WAIT) && (cnt == CNT_W'(1));
  assign busy_o = (state == S_WAIT);
  assign done_o = last;
  assign cap_o  = last & ~inb_we_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cnt         <= '0;
      inb_req_o   <= 1'b0;
      inb_we_o    <= 1'b0;
      inb_addr_o  <= '0;
      inb_wdata_o <= '0;
    end else begin
      inb_req_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          state       <= S_WAIT;
          cnt         <= CNT_W'(LAT);
          inb_req_o   <= 1'b1;
          inb_we_o    <= we_i;
          inb_addr_o  <= addr_i;
          inb_wdata_o <= wdata_i;
        end
        default: begin
          cnt <= cnt - CNT_W'(1);
          if (last) state <= S_IDLE;
        end
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    inb_req_o |=> !inb_req_o);                                      // R3
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    inb_req_o |-> busy_o);                                          // R3
  AST_BUSY_OPENS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> inb_req_o);                                   // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);                                            // R3
  AST_INNER_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !inb_req_o) |-> ($stable(inb_addr_o) && $stable(inb_we_o)
                                && $stable(inb_wdata_o)));          // R11
endmodule

// File: rtl/brg_irq.sv
module brg_irq
  import brg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               done_i,
  input  logic               sub_irq_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic [NUM_IRQ-1:0] ien_i,
  output logic [NUM_IRQ-1:0] flag_o,
  output logic               irq_o
);
  logic               sub_prev;
  logic [NUM_IRQ-1:0] set_v;

  always_comb begin
    set_v           = '0;
    set_v[IRQ_XFER] = done_i;
    set_v[IRQ_SUB]  = sub_irq_i & ~sub_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_prev <= 1'b0;
      flag_o   <= '0;
      irq_o    <= 1'b0;
    end else begin
      sub_prev <= sub_irq_i;
      flag_o   <= (flag_o & ~clr_i) | set_v;
      irq_o    <= |(flag_o & ien_i);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((flag_o & $past(set_v)) == $past(set_v)));        // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_v)) |=> ((flag_o & $past(clr_i & ~set_v)) == '0)); // R8
  AST_HELD_LEVEL_NO_SET: assert property (@(posedge clk) disable iff (rst)
    ($past(sub_irq_i) && !flag_o[IRQ_SUB]) |-> !set_v[IRQ_SUB]);    // R7
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import brg_pkg::*;
#(
  parameter int          HADDR_W  = 8,
  parameter int          LAT      = 2,
  parameter logic [31:0] ID_VALUE = 32'h0B1D_0100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hst_en,
  input  logic                hst_we,
  input  logic [HADDR_W-1:0]  hst_addr,
  input  logic [31:0]         hst_wdata,
  output logic [31:0]         hst_rdata,
  output logic                inb_req,
  output logic                inb_we,
  output logic [7:0]          inb_addr,
  output logic [7:0]          inb_wdata,
  input  logic [7:0]          inb_rdata,
  input  logic                sub_irq,
  output logic                host_irq
);
  logic                busy, cap, done, start, start_we;
  logic [INNER_AW-1:0] start_addr;
  logic [INNER_DW-1:0] start_wdata;
  logic [NUM_IRQ-1:0]  ien, fclr, flag;

  brg_host_regs #(.HADDR_W(HADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst), .hst_en(hst_en), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .busy_i(busy), .cap_i(cap),
    .cap_data_i(inb_rdata), .flag_i(flag), .start_o(start), .start_we_o(start_we),
    .start_addr_o(start_addr), .start_wdata_o(start_wdata), .ien_o(ien), .fclr_o(fclr)
  );

  brg_xfer_fsm #(.LAT(LAT)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start), .we_i(start_we), .addr_i(start_addr),
    .wdata_i(start_wdata), .busy_o(busy), .cap_o(cap), .done_o(done),
    .inb_req_o(inb_req), .inb_we_o(inb_we), .inb_addr_o(inb_addr), .inb_wdata_o(inb_wdata)
  );

  brg_irq u_irq (
    .clk(clk), .rst(rst), .done_i(done), .sub_irq_i(sub_irq), .clr_i(fclr),
    .ien_i(ien), .flag_o(flag), .irq_o(host_irq)
  );

  initial AST_LAT_MIN: assert (LAT >= 1);                           // R3
endmodule

// File: tb/test_ind_reg_bridge.sv
`timescale 1ns/1ps
module test_ind_reg_bridge;
  localparam int          LAT = 3;
  localparam logic [31:0] IDV = 32'hC0DE_0A5B;
  localparam logic [7:0]  A_ID = 8'h00, A_CTRL = 8'h04, A_LDAT = 8'h08,
                          A_UDAT = 8'h0C, A_IEN = 8'h10, A_IFLG = 8'h14;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic        hst_en = 1'b0, hst_we = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic        inb_req, inb_we, sub_irq = 1'b0, host_irq;
  logic [7:0]  inb_addr, inb_wdata, inb_rdata;

  ind_reg_bridge #(.HADDR_W(8), .LAT(LAT), .ID_VALUE(IDV)) i_ind_reg_bridge (
    .clk(clk), .rst(rst), .hst_en(hst_en), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .inb_req(inb_req), .inb_we(inb_we),
    .inb_addr(inb_addr), .inb_wdata(inb_wdata), .inb_rdata(inb_rdata),
    .sub_irq(sub_irq), .host_irq(host_irq)
  );

  // inner device model and reference copy
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int req_cnt = 0, win = 0, unstable = 0;
  logic [16:0] held;
  assign inb_rdata = mem[inb_addr];
  always @(posedge clk) begin
    if (inb_req) begin
      req_cnt <= req_cnt + 1;
      if (inb_we) mem[inb_addr] <= inb_wdata;
      win  <= LAT - 1;
      held <= {inb_we, inb_addr, inb_wdata};
    end else if (win > 0) begin
      win <= win - 1;
      if ({inb_we, inb_addr, inb_wdata} != held) unstable <= unstable + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [7:0] init_byte(input int i);
    return 8'(i * 37 + 11);
  endfunction
  function automatic logic [31:0] ctrl_view(input logic [31:0] d);
    return d & 32'h01FF_00FF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    hst_en = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_en = 1'b0; hst_we = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    hst_en = 1'b1; hst_we = 1'b0; hst_addr = a;
    @(negedge clk);
    hst_en = 1'b0;
    d = hst_rdata;
  endtask

  task automatic wait_idle(output int polls);
    logic [31:0] v;
    polls = 0;
    do begin
      hrd(A_CTRL, v);
      if (v[31]) polls++;
    end while (v[31] && polls < 1000);
  endtask

  task automatic inner_read(input logic [7:0] a, input string req);
    logic [31:0] v; int p, r0;
    r0 = req_cnt;
    hwr(A_CTRL, 32'h0101_0000 | 32'(a));
    wait_idle(p);
    chk(p == LAT, "R3 busy cycles on read", p, LAT);
    chk(req_cnt == r0 + 1, "R3 one request per read", req_cnt, r0 + 1);
    hrd(A_LDAT, v);
    chk(v == {24'h0, exp_mem[a]}, req, v, {24'h0, exp_mem[a]});
  endtask

  task automatic inner_write(input logic [7:0] a, input logic [7:0] d);
    int p;
    hwr(A_CTRL, 32'h0001_0000 | 32'(a));
    hwr(A_LDAT, {24'hA5A5A5, d});
    wait_idle(p);
    chk(p == LAT, "R4 busy cycles on write", p, LAT);
    exp_mem[a] = d;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p, r0;
    int unsigned seed;
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_byte(i);
      exp_mem[i] = init_byte(i);
    end
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    hrd(A_ID, v);   chk(v == IDV, "R1 id", v, IDV);
    hrd(A_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
    hrd(A_LDAT, v); chk(v == 0, "R1 ldat", v, 0);
    hrd(A_UDAT, v); chk(v == 0, "R1 udat", v, 0);
    hrd(A_IEN, v);  chk(v == 0, "R1 ien", v, 0);
    hrd(A_IFLG, v); chk(v == 0, "R1 iflg", v, 0);
    chk(host_irq == 1'b0, "R1 irq", 32'(host_irq), 0);

    // R2 control fields, write direction starts nothing
    r0 = req_cnt;
    hwr(A_CTRL, 32'hFEF5_AB3C);
    hrd(A_CTRL, v); chk(v == ctrl_view(32'hFEF5_AB3C), "R2 ctrl fields", v, ctrl_view(32'hFEF5_AB3C));
    chk(req_cnt == r0, "R2 no transfer", req_cnt, r0);

    // R4 data write with lane 0 enabled
    hwr(A_LDAT, 32'hDEAD_BEEF);
    wait_idle(p);
    chk(p == LAT, "R4 busy cycles", p, LAT);
    chk(req_cnt == r0 + 1, "R4 one request", req_cnt, r0 + 1);
    exp_mem[8'h3C] = 8'hEF;
    // R7 completion flag, R8 clear
    hrd(A_IFLG, v); chk(v == 1, "R7 xfer flag", v, 1);
    hwr(A_IFLG, 32'h0); hrd(A_IFLG, v); chk(v == 1, "R8 write 0 keeps", v, 1);
    hwr(A_IFLG, 32'h1); hrd(A_IFLG, v); chk(v == 0, "R8 write 1 clears", v, 0);

    // R3 read clears upper data bits
    inner_read(8'h3C, "R3 read back written byte");
    inner_read(8'h5A, "R3 read byte");

    // R4 lane 0 disabled: store only
    r0 = req_cnt;
    hwr(A_CTRL, 32'h00FE_0044);
    hwr(A_LDAT, 32'h0000_0077);
    hrd(A_CTRL, v); chk(v[31] == 1'b0, "R4 no busy without lane 0", v, 0);
    chk(req_cnt == r0, "R4 no request without lane 0", req_cnt, r0);
    hrd(A_LDAT, v); chk(v == 32'h77, "R4 stored only", v, 32'h77);
    inner_read(8'h44, "R4 inner byte untouched");

    // R5 writes ignored while busy
    r0 = req_cnt;
    hwr(A_CTRL, 32'h0101_005A);
    hwr(A_CTRL, 32'h0000_0033);
    hwr(A_UDAT, 32'h0000_1234);
    wait_idle(p);
    hrd(A_CTRL, v); chk(v == 32'h0101_005A, "R5 ctrl kept", v, 32'h0101_005A);
    hrd(A_UDAT, v); chk(v == 0, "R5 udat kept", v, 0);
    chk(req_cnt == r0 + 1, "R5 single transfer", req_cnt, r0 + 1);

    // R6 upper data storage
    r0 = req_cnt;
    hwr(A_CTRL, 32'h0001_0010);
    hwr(A_UDAT, 32'hA5A5_0F0F);
    hrd(A_UDAT, v); chk(v == 32'hA5A5_0F0F, "R6 udat rw", v, 32'hA5A5_0F0F);
    chk(req_cnt == r0, "R6 no transfer", req_cnt, r0);

    // R10 unmapped offsets
    hwr(8'h18, 32'hFFFF_FFFF);
    hrd(8'h18, v); chk(v == 0, "R10 unmapped 0x18", v, 0);
    hrd(8'h1C, v); chk(v == 0, "R10 unmapped 0x1C", v, 0);
    hrd(A_CTRL, v); chk(v == 32'h0001_0010, "R10 ctrl unchanged", v, 32'h0001_0010);

    // R7 sub interrupt edge, R8 collision
    hwr(A_IFLG, 32'h3);
    sub_irq = 1'b1;
    @(negedge clk);
    hrd(A_IFLG, v); chk(v == 2, "R7 sub edge sets", v, 2);
    hwr(A_IFLG, 32'h2);
    hrd(A_IFLG, v); chk(v == 0, "R7 held level no re-set", v, 0);
    sub_irq = 1'b0;
    @(negedge clk);
    sub_irq = 1'b1;
    hwr(A_IFLG, 32'h2);
    hrd(A_IFLG, v); chk(v == 2, "R8 set wins over clear", v, 2);
    sub_irq = 1'b0;

    // R9 interrupt output
    @(negedge clk);
    chk(host_irq == 1'b0, "R9 masked", 32'(host_irq), 0);
    hwr(A_IEN, 32'h2);
    @(negedge clk);
    chk(host_irq == 1'b1, "R9 enabled", 32'(host_irq), 1);
    hwr(A_IEN, 32'h1);
    @(negedge clk);
    chk(host_irq == 1'b0, "R9 other lane", 32'(host_irq), 0);
    hrd(A_IEN, v); chk(v == 1, "R9 ien readback", v, 1);
    hwr(A_IFLG, 32'h3);
    inner_read(8'h01, "R3 read for irq");
    chk(host_irq == 1'b1, "R9 xfer irq", 32'(host_irq), 1);
    hwr(A_IFLG, 32'h1);
    @(negedge clk);
    chk(host_irq == 1'b0, "R9 cleared", 32'(host_irq), 0);

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic [7:0] a, d;
      int op;
      op = int'($urandom % 3);
      a  = 8'($urandom);
      d  = 8'($urandom);
      if (op == 0) inner_read(a, "R3 random read");
      else if (op == 1) begin
        inner_write(a, d);
        if (k % 4 == 0) inner_read(a, "R4 random write read back");
      end else begin
        v = $urandom;
        hwr(A_UDAT, v);
        hrd(A_UDAT, hst_wdata);
        chk(hst_wdata == v, "R6 random udat", hst_wdata, v);
      end
    end

    chk(unstable == 0, "R11 inner outputs held", unstable, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule